// File: doc/BRIEF.md
# Embedded Interval, Fixed-Period and Watchdog Timer

This block sits beside a processor core and turns a free-running time base count into three timer events. A control register picks periods, enables and reset behaviour. A status register records what has happened. A down-counting interval timer can reload itself automatically. A fixed-period timer fires whenever a chosen time base bit rises. A watchdog passes through two warning stages before it asks for a reset of a chosen scope.

Software writes through a single register port and reads through a separate, combinational read select. The time base arrives as a count value. The block treats any change of that value as one tick, and it treats a 0-to-1 transition of a selected bit as a period expiry. Each interrupt line is the AND of a status bit and its enable. A status bit is cleared by writing a one to it, and that also drops the interrupt. The reset request is a one-cycle pulse that carries a type code. All ports are plain control and status pins, with no handshake and no back-pressure.

Top module: `tmr_unit`

## Requirements
- R1: Register selects are 0 = control, 1 = status, 2 = interval count/reload. A control write keeps only bits 31:22 (mask 0xFFC00000), and a control read returns them.
- R2: A status write clears every status bit in 31:26 whose written bit is one and leaves the other status bits unchanged.
- R3: With control bits 25:24 = k, a rising edge of time base bit 9+4k sets status bit 26. irq_fit is high only while status bit 26 and control bit 23 are both set.
- R4: A rising edge of a time base bit that the fixed-period select does not name leaves status bit 26 unchanged.
- R5: Writing select 2 loads the reload value and the count. The count drops by one for each cycle in which the time base value differs from the one before, and a read of select 2 returns the count.
- R6: When the count runs out (a tick while the count is 1), status bit 27 is set. irq_pit is high while status bit 27 and control bit 26 are both set.
- R7: At expiry the count reloads only if control bit 22 and control bit 26 are set and the reload value is above 1. Otherwise the count rests at 0 and further ticks leave it there.
- R8: An interval load of 1 or less, or a load made while control bit 26 is clear, does not start counting.
- R9: With control bits 31:30 = k, the watchdog expires on a rising edge of time base bit 17+4k. The first expiry sets status bit 31. The next expiry sets status bit 30, and irq_wdt follows status bit 30 AND control bit 27.
- R10: An expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28. In the following cycle rst_req carries that code (1 core, 2 chip, 3 system) for exactly one cycle. Code 0 gives no pulse.
- R11: After reset the control, status and count registers read zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_cnt | input | 32 | Time base count value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data for rd_sel |
| irq_pit | output | 1 | Interval timer interrupt |
| irq_fit | output | 1 | Fixed-period timer interrupt |
| irq_wdt | output | 1 | Watchdog interrupt |
| rst_req | output | 2 | Reset request code, one-cycle pulse |

## Verification
The bound checker covers the properties that hold on every cycle. It checks that a control write keeps only its upper ten bits. It checks that an idle interval count holds its value and never rises above the reload value. It checks that the watchdog interrupt status only rises after the first stage was already reached. It checks that a reset request is a single-cycle pulse whose code matches the recorded cause. The directed scenarios are needed for the behaviours that depend on sequences: which time base bit each period select watches, the auto-reload and stop decisions at expiry, the refusal to start on a small reload, write-one-to-clear on chosen bits, and the full three-stage watchdog walk, including the code-0 case that gives no pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned STS_W = 6;
  localparam logic [REG_W-1:0] CTL_KEEP = 32'hFFC0_0000;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_IVL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int unsigned C_WSEL_HI = 31;
  localparam int unsigned C_WSEL_LO = 30;
  localparam int unsigned C_RTYP_HI = 29;
  localparam int unsigned C_RTYP_LO = 28;
  localparam int unsigned C_WIE     = 27;
  localparam int unsigned C_PIE     = 26;
  localparam int unsigned C_FSEL_HI = 25;
  localparam int unsigned C_FSEL_LO = 24;
  localparam int unsigned C_FIE     = 23;
  localparam int unsigned C_ARE     = 22;

  // status register held as bits 31:26 -> index 5:0
  localparam int unsigned S_ENW  = 5;
  localparam int unsigned S_WIS  = 4;
  localparam int unsigned S_RC_HI = 3;
  localparam int unsigned S_RC_LO = 2;
  localparam int unsigned S_PIS  = 1;
  localparam int unsigned S_FIS  = 0;
endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel #(
  parameter int unsigned TB_W  = 32,
  parameter int unsigned BASE  = 9,
  parameter int unsigned STEP  = 4,
  parameter int unsigned NSEL  = 4,
  localparam int unsigned SEL_W = $clog2(NSEL)
) (
  input  logic [TB_W-1:0]  tb_now,
  input  logic [TB_W-1:0]  tb_prev,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [NSEL-1:0] rise;

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam int unsigned POS = BASE + STEP * g;
    assign rise[g] = tb_now[POS] & ~tb_prev[POS];
  end

  assign hit = rise[sel];
endmodule

// File: rtl/tmr_pit.sv
module tmr_pit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         ctl_wr,
  input  logic         ie,
  input  logic         are,
  output logic         expire,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         run_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic rld_ok;
  assign rld_ok = rld_q > ONE;
  assign expire = run_q && tick && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      run_q <= 1'b0;
    end else if (ld) begin
      rld_q <= ld_val;
      cnt_q <= ld_val;
      run_q <= (ld_val > ONE) && ie;
    end else begin
      if (expire) begin
        if (are && ie && rld_ok) begin
          cnt_q <= rld_q;
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else if (run_q && tick) begin
        cnt_q <= cnt_q - ONE;
      end
      if (ctl_wr && (!ie || !rld_ok)) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_wdt.sv
module tmr_wdt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       enw,
  input  logic       wis,
  input  logic [1:0] rtype,
  output logic       set_enw,
  output logic       set_wis,
  output logic       fire,
  output logic [1:0] rst_req
);
  assign set_enw = hit & ~enw;
  assign set_wis = hit & enw & ~wis;
  assign fire    = hit & enw & wis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 2'd0;
    else        rst_req <= fire ? rtype : 2'd0;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned TB_W     = 32,
  parameter int unsigned FIT_BASE = 9,
  parameter int unsigned WDT_BASE = 17,
  parameter int unsigned PER_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_cnt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_pit,
  output logic             irq_fit,
  output logic             irq_wdt,
  output logic [1:0]       rst_req
);
  localparam int unsigned NPER = 4;

  logic [TB_W-1:0]  tb_prev;
  logic [REG_W-1:0] tcr_q, tcr_d;
  logic [STS_W-1:0] tsr_q, tsr_d, tsr_clr, tsr_set;
  logic             tcr_wr, tsr_wr, ivl_wr, tick;
  logic             fit_hit, wdt_hit, pit_exp;
  logic             set_enw, set_wis, wdt_fire;
  logic [REG_W-1:0] pit_cnt, pit_rld;
  logic             pit_run;

  assign tcr_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
  assign tsr_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_STS);
  assign ivl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_IVL);
  assign tick   = tb_cnt != tb_prev;
  assign tcr_d  = tcr_wr ? (wr_data & CTL_KEEP) : tcr_q;

  tmr_edge_sel #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(PER_STEP), .NSEL(NPER)) u_fit_edge (
    .tb_now (tb_cnt),
    .tb_prev(tb_prev),
    .sel    (tcr_q[C_FSEL_HI:C_FSEL_LO]),
    .hit    (fit_hit)
  );

  tmr_edge_sel #(.TB_W(TB_W), .BASE(WDT_BASE), .STEP(PER_STEP), .NSEL(NPER)) u_wdt_edge (
    .tb_now (tb_cnt),
    .tb_prev(tb_prev),
    .sel    (tcr_q[C_WSEL_HI:C_WSEL_LO]),
    .hit    (wdt_hit)
  );

  tmr_pit #(.W(REG_W)) u_pit (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .ld    (ivl_wr),
    .ld_val(wr_data),
    .ctl_wr(tcr_wr),
    .ie    (tcr_d[C_PIE]),
    .are   (tcr_d[C_ARE]),
    .expire(pit_exp),
    .cnt_q (pit_cnt),
    .rld_q (pit_rld),
    .run_q (pit_run)
  );

  tmr_wdt u_wdt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (wdt_hit),
    .enw    (tsr_q[S_ENW]),
    .wis    (tsr_q[S_WIS]),
    .rtype  (tcr_q[C_RTYP_HI:C_RTYP_LO]),
    .set_enw(set_enw),
    .set_wis(set_wis),
    .fire   (wdt_fire),
    .rst_req(rst_req)
  );

  always_comb begin
    tsr_clr = tsr_wr ? wr_data[REG_W-1 -: STS_W] : '0;
    tsr_set = '0;
    tsr_set[S_ENW] = set_enw;
    tsr_set[S_WIS] = set_wis;
    tsr_set[S_PIS] = pit_exp;
    tsr_set[S_FIS] = fit_hit;
    tsr_d = (tsr_q & ~tsr_clr) | tsr_set;
    if (wdt_fire) tsr_d[S_RC_HI:S_RC_LO] = tcr_q[C_RTYP_HI:C_RTYP_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_prev <= '0;
      tcr_q   <= '0;
      tsr_q   <= '0;
    end else begin
      tb_prev <= tb_cnt;
      tcr_q   <= tcr_d;
      tsr_q   <= tsr_d;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CTL: rd_data = tcr_q;
      SEL_STS: rd_data = {tsr_q, {(REG_W-STS_W){1'b0}}};
      SEL_IVL: rd_data = pit_cnt;
      default: rd_data = '0;
    endcase
  end

  assign irq_pit = tsr_q[S_PIS] & tcr_q[C_PIE];
  assign irq_fit = tsr_q[S_FIS] & tcr_q[C_FIE];
  assign irq_wdt = tsr_q[S_WIS] & tcr_q[C_WIE];
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] tcr_q,
  input logic [5:0]  tsr_q,
  input logic [31:0] pit_cnt,
  input logic [31:0] pit_rld,
  input logic        pit_run,
  input logic        tick,
  input logic [1:0]  rst_req
);
  // R1
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> tcr_q == ($past(wr_data) & 32'hFFC0_0000));

  // R5
  ivl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pit_run && !tick && !(wr_en && wr_sel == 2'd2)) |=> $stable(pit_cnt));

  // R7
  ivl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pit_cnt <= pit_rld);

  // R9
  wdt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsr_q[4]) |-> $past(tsr_q[5]));

  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req != 2'd0) |=> (rst_req == 2'd0));

  // R10
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req != 2'd0) |-> (tsr_q[3:2] == rst_req));
endmodule

bind tmr_unit tmr_unit_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .tcr_q  (tcr_q),
  .tsr_q  (tsr_q),
  .pit_cnt(pit_cnt),
  .pit_rld(pit_rld),
  .pit_run(pit_run),
  .tick   (tick),
  .rst_req(rst_req)
);

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tb_cnt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_pit, irq_fit, irq_wdt;
  logic [1:0]  rst_req;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_pit(irq_pit),
    .irq_fit(irq_fit), .irq_wdt(irq_wdt), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic step_tb(input logic [31:0] v);
    @(negedge clk);
    tb_cnt = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R11 ctl", v, 32'h0);
    rd(2'd1, v); chk("R11 sts", v, 32'h0);
    rd(2'd2, v); chk("R11 ivl", v, 32'h0);
    chk("R11 outs", {27'd0, irq_pit, irq_fit, irq_wdt, rst_req}, 32'h0);
  endtask

  task automatic t_ctl();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R1 keep", v, 32'hFFC0_0000);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R1 zero", v, 32'h0);
  endtask

  task automatic t_fit();
    logic [31:0] v;
    wr(2'd0, 32'h0080_0000);          // fit irq on, sel 0 -> bit 9
    step_tb(32'h100);
    rd(2'd1, v); chk("R3 no edge", v, 32'h0);
    step_tb(32'h200);
    rd(2'd1, v); chk("R3 status", v, 32'h0400_0000);
    chk("R3 irq", {31'd0, irq_fit}, 32'h1);
    wr(2'd1, 32'h0400_0000);
    rd(2'd1, v); chk("R2 clear fit", v, 32'h0);
    chk("R2 irq drop", {31'd0, irq_fit}, 32'h0);
    wr(2'd0, 32'h0180_0000);          // sel 1 -> bit 13
    step_tb(32'h0);
    step_tb(32'h200);
    rd(2'd1, v); chk("R4 other bit", v, 32'h0);
    step_tb(32'h2000);
    rd(2'd1, v); chk("R4 chosen bit", v, 32'h0400_0000);
    wr(2'd1, 32'h0400_0000);
    wr(2'd0, 32'h0);                  // irq disabled, sel 0
    step_tb(32'h0);
    step_tb(32'h200);
    rd(2'd1, v); chk("R3 status w/o en", v, 32'h0400_0000);
    chk("R3 irq masked", {31'd0, irq_fit}, 32'h0);
    wr(2'd1, 32'hFC00_0000);
    step_tb(32'h0);
  endtask

  task automatic t_pit();
    logic [31:0] v;
    wr(2'd0, 32'h0440_0000);          // pit irq + auto-reload
    wr(2'd2, 32'd3);
    rd(2'd2, v); chk("R5 load", v, 32'd3);
    step_tb(32'd1);
    rd(2'd2, v); chk("R5 tick1", v, 32'd2);
    step_tb(32'd1);
    rd(2'd2, v); chk("R5 no change", v, 32'd2);
    step_tb(32'd2);
    rd(2'd2, v); chk("R5 tick2", v, 32'd1);
    step_tb(32'd3);
    rd(2'd2, v); chk("R7 reload", v, 32'd3);
    rd(2'd1, v); chk("R6 status", v, 32'h0800_0000);
    chk("R6 irq", {31'd0, irq_pit}, 32'h1);
    wr(2'd1, 32'h0800_0000);
    chk("R2 pit irq drop", {31'd0, irq_pit}, 32'h0);
    wr(2'd0, 32'h0400_0000);          // no auto-reload
    wr(2'd2, 32'd2);
    step_tb(32'd4);
    step_tb(32'd5);
    rd(2'd2, v); chk("R7 stop at 0", v, 32'd0);
    rd(2'd1, v); chk("R6 status2", v, 32'h0800_0000);
    step_tb(32'd6);
    rd(2'd2, v); chk("R7 stays 0", v, 32'd0);
    wr(2'd1, 32'h0800_0000);
    wr(2'd0, 32'h0440_0000);
    wr(2'd2, 32'd1);
    step_tb(32'd7);
    rd(2'd2, v); chk("R8 small load", v, 32'd1);
    wr(2'd0, 32'h0040_0000);          // irq enable off
    wr(2'd2, 32'd5);
    step_tb(32'd8);
    rd(2'd2, v); chk("R8 no enable", v, 32'd5);
    rd(2'd1, v); chk("R8 no status", v, 32'h0);
    step_tb(32'h0);
  endtask

  task automatic t_wdt();
    logic [31:0] v;
    wr(2'd0, 32'h2800_0000);          // wdt irq, chip reset, sel 0 -> bit 17
    step_tb(32'h2_0000);
    rd(2'd1, v); chk("R9 stage1", v, 32'h8000_0000);
    chk("R9 no irq yet", {31'd0, irq_wdt}, 32'h0);
    step_tb(32'h0);
    step_tb(32'h2_0000);
    rd(2'd1, v); chk("R9 stage2", v, 32'hC000_0000);
    chk("R9 irq", {31'd0, irq_wdt}, 32'h1);
    step_tb(32'h0);
    step_tb(32'h2_0000);
    rd(2'd1, v); chk("R10 cause", v, 32'hE000_0000);
    chk("R10 pulse", {30'd0, rst_req}, 32'd2);
    @(posedge clk); @(negedge clk);
    chk("R10 one cycle", {30'd0, rst_req}, 32'd0);
    wr(2'd1, 32'h4000_0000);
    rd(2'd1, v); chk("R2 partial clear", v, 32'hA000_0000);
    chk("R2 wdt irq drop", {31'd0, irq_wdt}, 32'h0);
    wr(2'd1, 32'hFC00_0000);
    rd(2'd1, v); chk("R2 clear all", v, 32'h0);
    wr(2'd0, 32'h0);                  // reset code 0
    for (int i = 0; i < 3; i++) begin
      step_tb(32'h0);
      step_tb(32'h2_0000);
      chk("R10 code0 none", {30'd0, rst_req}, 32'd0);
    end
    rd(2'd1, v); chk("R10 code0 status", v, 32'hC000_0000);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctl();
    t_fit();
    t_pit();
    t_wdt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule